// File: doc/BRIEF.md
# Divide-by-Six Byte Address Splitter

This block turns a byte address into the index of the 48-bit memory word that holds the byte, together with the byte's position inside that word. Each word carries six 8-bit bytes, so the word index is the address divided by six and the position is the remainder. No divider is built. The quotient comes from a multiply by a fixed reciprocal of six, plus a rounding constant, followed by a right shift. The multiply is a tree of shifted copies of the address, summed over registered levels.

A new address can enter on every clock cycle. Each result leaves after a fixed number of cycles, with a valid flag that moves through the pipeline alongside it. The number of cycles is four core stages plus a parameter-selected count of extra output registers. The address is 15 bits wide. That is the range over which the reciprocal method has been shown to give the exact quotient.

Top module: `div6_index_conv`

## Requirements
- R1: For every valid input address A from 0 through 32767, `out_index` equals floor(A / 6).
- R2: For every valid result, `out_offset` equals A − 6·`out_index` and lies in 0 to 5 (3-bit unsigned code).
- R3: Addresses 0 to 5 give word index 0 with offsets 0 to 5 in order, and address 6 gives word index 1 with offset 0.
- R4: Address 0 gives word index 0 and offset 0.
- R5: An input presented with `in_valid` high before clock edge n appears on the outputs with `out_valid` high right after edge n+L−1, where L = 4 + EXTRA_STAGES. `out_valid` is low in every cycle that matches a cycle with `in_valid` low.
- R6: Inputs on back-to-back cycles give results on back-to-back cycles, one per cycle, in input order.
- R7: Reset is synchronous and active high. After any clock edge with `rst` high, `out_valid` is low, and results that were in flight are discarded.
- R8: The top address 32767 gives word index 5461 and offset 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_addr` as a request in this cycle |
| in_addr | input | 15 | Byte address |
| out_valid | output | 1 | Marks the result outputs as holding a result |
| out_index | output | 13 | Word index, the address divided by six |
| out_offset | output | 3 | Byte position within the word, 0 to 5 |

## Verification
The bench instantiates the block with EXTRA_STAGES set to 2, which gives a six-cycle latency. This exercises the generated output delay chain as well as the four core stages, and makes the expected arrival cycle differ from the core depth, so an error of a single stage shows up. With that setting, a stream of all 32768 addresses, one per cycle, runs through the pipeline. This covers every rounding case of the reciprocal method at every remainder value, across the full address range. Timing is checked separately, using isolated requests, inputs with idle cycles between them, and a reset applied while results are in flight.

// File: rtl/div6_pkg.sv
package div6_pkg;

    // Width of the byte address; the reciprocal method is exact up to here.
    localparam int ADDR_W      = 15;
    // Bytes held by one memory word.
    localparam int BYTES_PER_W = 6;
    // Largest word index reachable from the top address.
    localparam int MAX_INDEX   = ((1 << ADDR_W) - 1) / BYTES_PER_W;
    localparam int WORD_W      = $clog2(MAX_INDEX + 1);
    localparam int OFF_W       = $clog2(BYTES_PER_W);
    // Reciprocal 0xAAAA has ones at bit 1,3,...,15: eight shifted terms.
    localparam int N_TERMS     = 8;
    localparam int SHIFT       = 18;
    localparam int PROD_W      = ADDR_W + 16;
    localparam int ROUND       = 1 << 15;
    // Register stages in the core path: two tree levels, quotient, result.
    localparam int CORE_STAGES = 4;

    typedef logic [PROD_W-1:0] prod_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] index;
        logic [OFF_W-1:0]  offset;
    } result_t;

    localparam int RES_W = $bits(result_t);

    // Term t of the reciprocal product: the address shifted by 2t+1.
    function automatic prod_t recip_term(input logic [ADDR_W-1:0] a, input int t);
        return prod_t'(a) << (2 * t + 1);
    endfunction

    // Six times a quotient, built as 4q + 2q.
    function automatic logic [ADDR_W-1:0] times_six(input logic [WORD_W-1:0] q);
        return ADDR_W'({q, 2'b00}) + ADDR_W'({q, 1'b0});
    endfunction

endpackage

// File: rtl/div6_pair_adder.sv
module div6_pair_adder
    import div6_pkg::*;
#(
    parameter int IN_N = 8
) (
    input  logic                   clk,
    input  prod_t [IN_N-1:0]       din,
    output prod_t [IN_N/2-1:0]     dout
);
    localparam int OUT_N = IN_N / 2;

    for (genvar j = 0; j < OUT_N; j++) begin : g_pair
        always_ff @(posedge clk) begin
            dout[j] <= din[2*j] + din[2*j+1];
        end
    end

endmodule

// File: rtl/div6_remainder.sv
module div6_remainder
    import div6_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] quot,
    output logic [OFF_W-1:0]  offset
);
    logic [ADDR_W-1:0] base;

    always_comb begin
        base   = times_six(quot);
        offset = OFF_W'(addr - base);
    end

endmodule

// File: rtl/div6_delay.sv
module div6_delay
    import div6_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic    clk,
    input  logic    rst,
    input  result_t din,
    output result_t dout
);
    result_t stage_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= din;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/div6_index_conv.sv
module div6_index_conv
    import div6_pkg::*;
#(
    parameter int EXTRA_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_index,
    output logic [OFF_W-1:0]  out_offset
);
    localparam int ALIGN = CORE_STAGES - 1;

    // Shifted copies of the address that sum to address * 0xAAAA.
    prod_t [N_TERMS-1:0]   terms;
    prod_t [N_TERMS/2-1:0] lvl1;
    prod_t [N_TERMS/4-1:0] lvl2;

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        assign terms[t] = recip_term(in_addr, t);
    end

    div6_pair_adder #(.IN_N(N_TERMS)) u_lvl1 (
        .clk  (clk),
        .din  (terms),
        .dout (lvl1)
    );

    div6_pair_adder #(.IN_N(N_TERMS/2)) u_lvl2 (
        .clk  (clk),
        .din  (lvl1),
        .dout (lvl2)
    );

    // Last tree level with the rounding constant, then the shift.
    logic [WORD_W-1:0] quot_q;
    always_ff @(posedge clk) begin
        quot_q <= WORD_W'((lvl2[0] + lvl2[1] + prod_t'(ROUND)) >> SHIFT);
    end

    // Address and valid travel beside the tree.
    logic [ADDR_W-1:0] addr_d [ALIGN];
    logic [ALIGN-1:0]  vld_d;

    always_ff @(posedge clk) begin
        if (rst) vld_d <= '0;
        else     vld_d <= {vld_d[ALIGN-2:0], in_valid};
    end

    for (genvar s = 0; s < ALIGN; s++) begin : g_align
        always_ff @(posedge clk) begin
            if (s == 0) addr_d[s] <= in_addr;
            else        addr_d[s] <= addr_d[(s == 0) ? 0 : s-1];
        end
    end

    logic [OFF_W-1:0] off_c;
    div6_remainder u_rem (
        .addr   (addr_d[ALIGN-1]),
        .quot   (quot_q),
        .offset (off_c)
    );

    result_t core_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '0;
        end else begin
            core_q.valid  <= vld_d[ALIGN-1];
            core_q.index  <= quot_q;
            core_q.offset <= off_c;
        end
    end

    result_t final_res;
    if (EXTRA_STAGES > 0) begin : g_extra
        div6_delay #(.DEPTH(EXTRA_STAGES)) u_delay (
            .clk  (clk),
            .rst  (rst),
            .din  (core_q),
            .dout (final_res)
        );
    end else begin : g_direct
        assign final_res = core_q;
    end

    assign out_valid  = final_res.valid;
    assign out_index  = final_res.index;
    assign out_offset = final_res.offset;

endmodule

// File: rtl/div6_index_conv_chk.sv
module div6_index_conv_chk
    import div6_pkg::*;
#(
    parameter int EXTRA_STAGES = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_index,
    input logic [OFF_W-1:0]  out_offset
);
    localparam int LAT = CORE_STAGES + EXTRA_STAGES;

    logic [LAT-1:0]    v_sr;
    logic [ADDR_W-1:0] a_sr [LAT];
    logic              rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) v_sr <= '0;
        else     v_sr <= {v_sr[LAT-2:0], in_valid};
    end

    for (genvar s = 0; s < LAT; s++) begin : g_sr
        always_ff @(posedge clk) begin
            if (s == 0) a_sr[s] <= in_addr;
            else        a_sr[s] <= a_sr[(s == 0) ? 0 : s-1];
        end
    end

    // R5 / R6: valid flag arrives exactly LAT stages after the request
    a_r5_valid_timing: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_sr[LAT-1]);

    // R2: offset stays inside a word
    a_r2_offset_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_offset < OFF_W'(BYTES_PER_W)));

    // R1: index and offset rebuild the address that entered LAT stages earlier
    a_r1_recombine: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (({3'b000, out_index} * 16'd6 + 16'(out_offset)) == 16'(a_sr[LAT-1])));

    // R4: address zero maps to word zero, byte zero
    a_r4_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (out_valid && a_sr[LAT-1] == '0) |-> (out_index == '0 && out_offset == '0));

    // R8: index never exceeds the one for the top address
    a_r8_index_bound: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_index <= WORD_W'(MAX_INDEX)));

    // R7: a reset edge leaves out_valid low
    always @(negedge clk) begin
        if (rst_q) begin
            a_r7_reset_clears: assert (!out_valid);
        end
    end

endmodule

bind div6_index_conv div6_index_conv_chk #(.EXTRA_STAGES(EXTRA_STAGES)) u_chk (.*);

// File: tb/div6_index_conv_test.sv
`timescale 1ns/1ps
module div6_index_conv_test;
    import div6_pkg::*;

    localparam int EXTRA = 2;
    localparam int LAT   = 4 + EXTRA;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic              out_valid;
    logic [WORD_W-1:0] out_index;
    logic [OFF_W-1:0]  out_offset;

    int total = 0;
    int bad   = 0;
    int edge_n = 0;
    int wd = 0;
    bit mon_en = 1'b0;
    string mon_tag = "R1";

    logic [63:0]       ring_v = '0;
    logic [ADDR_W-1:0] ring_a [64];

    always #2 clk = ~clk;   // 250 MHz

    div6_index_conv #(.EXTRA_STAGES(EXTRA)) uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_addr    (in_addr),
        .out_valid  (out_valid),
        .out_index  (out_index),
        .out_offset (out_offset)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Record what the block sampled at each edge.
    always @(posedge clk) begin
        edge_n++;
        ring_v[edge_n % 64] = in_valid & ~rst;
        ring_a[edge_n % 64] = in_addr;
    end

    // Continuous model: result for the input sampled LAT-1 edges back.
    always @(negedge clk) begin
        if (mon_en && edge_n >= LAT) begin
            int k;
            int a;
            k = (edge_n - LAT + 1) % 64;
            a = int'(ring_a[k]);
            check(out_valid == ring_v[k], "R5", "out_valid", int'(out_valid), int'(ring_v[k]));
            if (ring_v[k]) begin
                check(int'(out_index) == a / 6, mon_tag, "index", int'(out_index), a / 6);
                check(int'(out_offset) == a % 6, "R2", "offset", int'(out_offset), a % 6);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // R7: reset state
    task automatic t_reset;
        mon_en = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        in_addr = 15'd7;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
        in_valid = 1'b0;
        rst = 1'b0;
        idle(LAT + 1);
        check(out_valid == 1'b0, "R7", "out_valid after reset", int'(out_valid), 0);
        mon_en = 1'b1;
    endtask

    // Single request with explicit arrival-cycle checks.
    task automatic apply_one(input int a, input int exp_idx, input int exp_off, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = ADDR_W'(a);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 2) @(negedge clk);
        check(out_valid == 1'b0, "R5", "early out_valid", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R5", "out_valid at latency", int'(out_valid), 1);
        check(int'(out_index) == exp_idx, req, "index", int'(out_index), exp_idx);
        check(int'(out_offset) == exp_off, req, "offset", int'(out_offset), exp_off);
        @(negedge clk);
        check(out_valid == 1'b0, "R5", "late out_valid", int'(out_valid), 0);
    endtask

    // R3: first words back to back
    task automatic t_first_words;
        mon_tag = "R3";
        for (int a = 0; a < 13; a++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_addr  = ADDR_W'(a);
        end
        idle(LAT + 1);
        apply_one(6, 1, 0, "R3");
        apply_one(5, 0, 5, "R3");
    endtask

    task automatic t_zero;
        apply_one(0, 0, 0, "R4");
    endtask

    task automatic t_max;
        apply_one(32767, 5461, 1, "R8");
    endtask

    // R1 / R6: every address, one per cycle
    task automatic t_sweep;
        mon_tag = "R1";
        for (int a = 0; a < 32768; a++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_addr  = ADDR_W'(a);
        end
        idle(LAT + 1);
    endtask

    // R5 / R6: gaps and bursts interleaved
    task automatic t_gaps;
        mon_tag = "R6";
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            in_valid = (i % 3 != 1) && (i % 7 != 0);
            in_addr  = ADDR_W'((i * 1237 + 11) % 32768);
        end
        idle(LAT + 1);
    endtask

    // R7: reset with results in flight
    task automatic t_midreset;
        mon_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_addr  = ADDR_W'(100 + i);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R7", "out_valid after mid reset", int'(out_valid), 0);
        rst = 1'b0;
        for (int i = 0; i < LAT + 1; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R7", "flushed result", int'(out_valid), 0);
        end
        mon_en = 1'b1;
    endtask

    initial begin
        t_reset();
        t_first_words();
        t_zero();
        t_max();
        t_gaps();
        t_midreset();
        t_sweep();
        apply_one(32766, 5461, 0, "R1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule